// File: doc/BRIEF.md
# Card Clock Source Selector and Glitch-Free Divider

The block produces two clocks for a smart-card reader front end. The card clock goes to the card contact. The host clock goes back to the controller. Three sources are available: a crystal, an internal RC oscillator and an external clock that the host supplies for synchronous cards.

The design runs on one fast system clock. The crystal and the RC oscillator arrive as one-cycle tick pulses, with one tick for each edge (half period) of the source. The external clock arrives as a level that the block samples.

Four control inputs choose the card clock. The card clock can be the crystal divided by 2 or 4, the RC clock divided by 2, a copy of the external clock, or held low. A low-power mode overrides the other selects. A sequencer enable can also hold the card clock low. A new selection is adopted only while the card clock is low, so no short high or low phase ever appears at the card.

Top module: `cardclk_sel`

## Requirements
- R1: During reset and directly after it, `cardClk` and `hostClk` are low.
- R2: With `normalMode`=1, `srcSel`=0, `divA`=1 and `divB`=0, `cardClk` and `hostClk` each toggle once every 2 `rcTick` pulses.
- R3: With `normalMode`=1, `srcSel`=0, `divA`=0 and `divB`=0, `cardClk` toggles every 4 `xtalTick` pulses, and `hostClk` toggles on every `xtalTick`.
- R4: With `normalMode`=1, `srcSel`=0, `divA`=0 and `divB`=1, `cardClk` toggles every 2 `xtalTick` pulses, and `hostClk` toggles on every `xtalTick`.
- R5: With `normalMode`=1, `srcSel`=0, `divA`=1 and `divB`=1, `cardClk` stops low and `hostClk` toggles on every `xtalTick`.
- R6: With `normalMode`=1 and `srcSel`=1, `cardClk` equals `extClk` one cycle later, whatever `divA` and `divB` are. `hostClk` toggles on every `xtalTick`.
- R7: With `normalMode`=0, `cardClk` stops low and `hostClk` toggles every 2 `rcTick` pulses, whatever the other selects are.
- R8: While `clkEn` is low, `cardClk` is low from the next cycle on. After `clkEn` returns high, the first low phase covers at least one full divided low phase of the current setting, less one source tick.
- R9: A new selection is adopted only while `cardClk` is low. A change requested during a high phase lets that high phase run to its full length.
- R10: When switching between the divided and stopped settings, no high or low phase of `cardClk` is shorter than 3 system cycles. This holds with `xtalTick` every 2 cycles and `rcTick` every 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| normalMode | input | 1 | 1 = normal operation, 0 = low-power override |
| srcSel | input | 1 | 1 = card clock follows the external clock |
| divA | input | 1 | First divider select |
| divB | input | 1 | Second divider select |
| clkEn | input | 1 | Card clock enable from the sequencer |
| xtalTick | input | 1 | One-cycle pulse on each crystal edge |
| rcTick | input | 1 | One-cycle pulse on each RC oscillator edge |
| extClk | input | 1 | External clock level for synchronous cards |
| cardClk | output | 1 | Clock to the card |
| hostClk | output | 1 | Clock back to the host |

## Verification
Two events can land on the same system cycle: a selection change and the edge at which the running divider ends its high phase. When they meet, the block must drive the falling edge and adopt the new source in one step, without ever driving a runt.

The stimulus table provokes this by changing the selects while the clock is running. The bench also makes a directed change the cycle after a rising edge and checks that the high phase still lasts its full length.

A monitor judges both cases by timing every phase of the card clock against a minimum length. Separately, gating by the enable is checked to win over a pending switch without shortening the restart.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

  // Active card clock source after glitch-free switching.
  typedef enum logic [2:0] {
    SRC_STOP    = 3'd0,
    SRC_XT_FAST = 3'd1,
    SRC_XT_SLOW = 3'd2,
    SRC_RC      = 3'd3,
    SRC_EXT     = 3'd4
  } cardSrc_e;

  // Strobes from control to datapath.
  typedef struct packed {
    cardSrc_e src;   // source in force this cycle
    logic     load;  // a new source is adopted at this edge
    logic     gate;  // sequencer enable is low
  } clkCmd_t;

endpackage

// File: rtl/cardclk_ctrl.sv
module cardclk_ctrl
  import cardclk_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    normalMode,
  input  logic    srcSel,
  input  logic    divA,
  input  logic    divB,
  input  logic    clkEn,
  input  logic    cardClk,
  input  logic    fallNow,
  output clkCmd_t cmd,
  output logic    hostUseRc
);

  cardSrc_e reqSrc;
  cardSrc_e activeSrc;
  logic     commit;

  // Decode of the four select inputs; low power overrides everything.
  always_comb begin
    if (!normalMode)          reqSrc = SRC_STOP;
    else if (srcSel)          reqSrc = SRC_EXT;
    else if (divA && !divB)   reqSrc = SRC_RC;
    else if (!divA && !divB)  reqSrc = SRC_XT_SLOW;
    else if (!divA && divB)   reqSrc = SRC_XT_FAST;
    else                      reqSrc = SRC_STOP;
  end

  // Adopt a new source only while the card clock is low, or on the
  // edge at which the running divider drives it low.
  assign commit = (reqSrc != activeSrc) && (!cardClk || fallNow);

  always_ff @(posedge clk) begin
    if (rst)         activeSrc <= SRC_STOP;
    else if (commit) activeSrc <= reqSrc;
  end

  always_comb begin
    cmd.src  = activeSrc;
    cmd.load = commit;
    cmd.gate = !clkEn;
  end

  assign hostUseRc = !normalMode || (!srcSel && divA && !divB);

endmodule

// File: rtl/cardclk_dp.sv
module cardclk_dp
  import cardclk_pkg::*;
#(
  parameter int unsigned FAST_DIV    = 2,
  parameter int unsigned SLOW_DIV    = 4,
  parameter int unsigned RC_DIV      = 2,
  parameter int unsigned HOST_RC_DIV = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    xtalTick,
  input  logic    rcTick,
  input  logic    extClk,
  input  clkCmd_t cmd,
  input  logic    hostUseRc,
  output logic    cardClk,
  output logic    hostClk,
  output logic    fallNow
);

  localparam int unsigned MAX_DIV = (SLOW_DIV > FAST_DIV) ?
                                    ((SLOW_DIV > RC_DIV) ? SLOW_DIV : RC_DIV) :
                                    ((FAST_DIV > RC_DIV) ? FAST_DIV : RC_DIV);
  localparam int unsigned CW  = $clog2(MAX_DIV + 1);
  localparam int unsigned HCW = $clog2(HOST_RC_DIV + 1);
  localparam logic [CW-1:0]  FAST_LAST = CW'(FAST_DIV - 1);
  localparam logic [CW-1:0]  SLOW_LAST = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0]  RC_LAST   = CW'(RC_DIV - 1);
  localparam logic [HCW-1:0] HOST_LAST = HCW'(HOST_RC_DIV - 1);

  logic [CW-1:0]  phaseCnt;
  logic [CW-1:0]  lastIdx;
  logic           srcTick;
  logic           divided;
  logic           endOfHalf;
  logic [HCW-1:0] hostCnt;

  always_comb begin
    srcTick = xtalTick;
    divided = 1'b1;
    lastIdx = FAST_LAST;
    case (cmd.src)
      SRC_XT_FAST: lastIdx = FAST_LAST;
      SRC_XT_SLOW: lastIdx = SLOW_LAST;
      SRC_RC: begin
        lastIdx = RC_LAST;
        srcTick = rcTick;
      end
      default: divided = 1'b0;
    endcase
  end

  assign endOfHalf = divided && srcTick && (phaseCnt == lastIdx);
  assign fallNow   = endOfHalf && cardClk && !cmd.gate;

  // Card clock: one half period is a count of source ticks.
  always_ff @(posedge clk) begin
    if (rst || cmd.gate || cmd.load) begin
      cardClk  <= 1'b0;
      phaseCnt <= '0;
    end else begin
      case (cmd.src)
        SRC_STOP: begin
          cardClk  <= 1'b0;
          phaseCnt <= '0;
        end
        SRC_EXT: begin
          cardClk  <= extClk;
          phaseCnt <= '0;
        end
        default: begin
          if (endOfHalf) begin
            cardClk  <= ~cardClk;
            phaseCnt <= '0;
          end else if (srcTick) begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
      endcase
    end
  end

  // Host clock: the crystal itself, or the RC clock divided down.
  generate
    if (HOST_RC_DIV > 1) begin : g_hostDiv
      always_ff @(posedge clk) begin
        if (rst) begin
          hostClk <= 1'b0;
          hostCnt <= '0;
        end else if (hostUseRc) begin
          if (rcTick) begin
            if (hostCnt == HOST_LAST) begin
              hostClk <= ~hostClk;
              hostCnt <= '0;
            end else begin
              hostCnt <= hostCnt + 1'b1;
            end
          end
        end else begin
          hostCnt <= '0;
          if (xtalTick) hostClk <= ~hostClk;
        end
      end
    end else begin : g_hostDirect
      assign hostCnt = '0;
      always_ff @(posedge clk) begin
        if (rst)                          hostClk <= 1'b0;
        else if (hostUseRc ? rcTick : xtalTick) hostClk <= ~hostClk;
      end
    end
  endgenerate

endmodule

// File: rtl/cardclk_sel.sv
module cardclk_sel
  import cardclk_pkg::*;
#(
  parameter int unsigned FAST_DIV    = 2,
  parameter int unsigned SLOW_DIV    = 4,
  parameter int unsigned RC_DIV      = 2,
  parameter int unsigned HOST_RC_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic normalMode,
  input  logic srcSel,
  input  logic divA,
  input  logic divB,
  input  logic clkEn,
  input  logic xtalTick,
  input  logic rcTick,
  input  logic extClk,
  output logic cardClk,
  output logic hostClk
);

  clkCmd_t cmd;
  logic    hostUseRc;
  logic    fallNow;

  cardclk_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .normalMode(normalMode),
    .srcSel    (srcSel),
    .divA      (divA),
    .divB      (divB),
    .clkEn     (clkEn),
    .cardClk   (cardClk),
    .fallNow   (fallNow),
    .cmd       (cmd),
    .hostUseRc (hostUseRc)
  );

  cardclk_dp #(
    .FAST_DIV   (FAST_DIV),
    .SLOW_DIV   (SLOW_DIV),
    .RC_DIV     (RC_DIV),
    .HOST_RC_DIV(HOST_RC_DIV)
  ) i_dp (
    .clk      (clk),
    .rst      (rst),
    .xtalTick (xtalTick),
    .rcTick   (rcTick),
    .extClk   (extClk),
    .cmd      (cmd),
    .hostUseRc(hostUseRc),
    .cardClk  (cardClk),
    .hostClk  (hostClk),
    .fallNow  (fallNow)
  );

endmodule

// File: rtl/cardclk_sva.sv
module cardclk_sva
  import cardclk_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    normalMode,
  input logic    srcSel,
  input logic    divA,
  input logic    divB,
  input logic    clkEn,
  input logic    extClk,
  input logic    cardClk,
  input clkCmd_t cmd
);

  assert_gate_low_R8: assert property (@(posedge clk) disable iff (rst)
    !clkEn |=> !cardClk);

  assert_sleep_low_R7: assert property (@(posedge clk) disable iff (rst)
    (!normalMode && !cardClk) |=> !cardClk);

  assert_stop_low_R5: assert property (@(posedge clk) disable iff (rst)
    (normalMode && !srcSel && divA && divB && !cardClk) |=> !cardClk);

  assert_switch_low_R9: assert property (@(posedge clk) disable iff (rst)
    cmd.load |=> !cardClk);

  assert_ext_follow_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd.src == SRC_EXT && !cmd.load && !cmd.gate) |=> (cardClk == $past(extClk)));

endmodule

bind cardclk_sel cardclk_sva i_sva (
  .clk       (clk),
  .rst       (rst),
  .normalMode(normalMode),
  .srcSel    (srcSel),
  .divA      (divA),
  .divB      (divB),
  .clkEn     (clkEn),
  .extClk    (extClk),
  .cardClk   (cardClk),
  .cmd       (cmd)
);

// File: tb/test_cardclk_sel.sv
module test_cardclk_sel;

  logic clk = 1'b0;
  logic rst, normalMode, srcSel, divA, divB, clkEn, xtalTick, rcTick, extClk;
  logic cardClk, hostClk;

  int vectors = 0;
  int miscompares = 0;
  bit phaseCheckOn = 1'b0;
  int phaseLen = 0;
  logic prevCard = 1'b0;

  localparam int MIN_PHASE = 3;

  // {normalMode, srcSel, divA, divB, card half (cycles, 0 = stopped), host half}
  localparam logic [19:0] VEC [8] = '{
    {4'b1010, 8'd6, 8'd6},   // RC / 2
    {4'b1000, 8'd8, 8'd2},   // crystal / 4
    {4'b1001, 8'd4, 8'd2},   // crystal / 2
    {4'b1011, 8'd0, 8'd2},   // stopped
    {4'b1000, 8'd8, 8'd2},
    {4'b0011, 8'd0, 8'd6},   // low power
    {4'b1001, 8'd4, 8'd2},
    {4'b1010, 8'd6, 8'd6}
  };

  always #2 clk = ~clk;

  cardclk_sel i_cardclk_sel (
    .clk(clk), .rst(rst), .normalMode(normalMode), .srcSel(srcSel),
    .divA(divA), .divB(divB), .clkEn(clkEn), .xtalTick(xtalTick),
    .rcTick(rcTick), .extClk(extClk), .cardClk(cardClk), .hostClk(hostClk)
  );

  // Source ticks: crystal edge every 2 cycles, RC edge every 3 cycles.
  initial begin
    int xc = 0;
    int rc = 0;
    xtalTick = 1'b0;
    rcTick = 1'b0;
    forever begin
      @(negedge clk);
      xc = (xc + 1) % 2;
      rc = (rc + 1) % 3;
      xtalTick = (xc == 0);
      rcTick = (rc == 0);
    end
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R10 phase monitor: every card clock phase is timed.
  always @(negedge clk) begin
    if (cardClk !== prevCard) begin
      if (phaseCheckOn) check(phaseLen >= MIN_PHASE, "R10 phase length", phaseLen, MIN_PHASE);
      phaseLen = 1;
      prevCard = cardClk;
    end else begin
      phaseLen++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finishRun();
  end

  function automatic logic pick(input bit host);
    return host ? hostClk : cardClk;
  endfunction

  // Length in cycles of one full phase, after skipping a partial one.
  task automatic measureHalf(input bit host, output int len);
    logic s0;
    int n;
    len = -1;
    for (int k = 0; k < 2; k++) begin
      s0 = pick(host);
      n = 0;
      while (pick(host) == s0 && n < 100) begin @(negedge clk); n++; end
      if (n >= 100) return;
    end
    s0 = pick(host);
    n = 0;
    while (pick(host) == s0 && n < 100) begin @(negedge clk); n++; end
    if (n < 100) len = n;
  endtask

  function automatic string tagOf(input logic [3:0] s);
    if (!s[3]) return "R7";
    if (s[2]) return "R6";
    if (s[1] && !s[0]) return "R2";
    if (!s[1] && !s[0]) return "R3";
    if (!s[1] && s[0]) return "R4";
    return "R5";
  endfunction

  initial begin
    int len;
    int n;
    bit lowAll;
    rst = 1'b1;
    normalMode = 1'b1; srcSel = 1'b0; divA = 1'b1; divB = 1'b1;
    clkEn = 1'b1; extClk = 1'b0;
    repeat (5) @(negedge clk);
    check(cardClk == 1'b0, "R1 card in reset", int'(cardClk), 0);
    check(hostClk == 1'b0, "R1 host in reset", int'(hostClk), 0);
    rst = 1'b0;
    @(negedge clk);
    check(cardClk == 1'b0, "R1 card after reset", int'(cardClk), 0);
    check(hostClk == 1'b0, "R1 host after reset", int'(hostClk), 0);
    repeat (10) @(negedge clk);
    phaseCheckOn = 1'b1;

    // Table walk, switching while the card clock runs.
    for (int v = 0; v < 8; v++) begin
      {normalMode, srcSel, divA, divB} = VEC[v][19:16];
      repeat (30) @(negedge clk);
      if (VEC[v][15:8] == 8'd0) begin
        lowAll = 1'b1;
        for (int c = 0; c < 40; c++) begin
          @(negedge clk);
          if (cardClk) lowAll = 1'b0;
        end
        check(lowAll, {tagOf(VEC[v][19:16]), " card stopped low"}, int'(!lowAll), 0);
      end else begin
        measureHalf(1'b0, len);
        check(len == int'(VEC[v][15:8]), {tagOf(VEC[v][19:16]), " card half"},
              len, int'(VEC[v][15:8]));
      end
      measureHalf(1'b1, len);
      check(len == int'(VEC[v][7:0]), {tagOf(VEC[v][19:16]), " host half"},
            len, int'(VEC[v][7:0]));
    end

    // R9: request crystal/2 just after a rise in crystal/4.
    {normalMode, srcSel, divA, divB} = 4'b1000;
    repeat (40) @(negedge clk);
    while (cardClk) @(negedge clk);
    while (!cardClk) @(negedge clk);
    divB = 1'b1;
    n = 0;
    while (cardClk && n < 100) begin n++; @(negedge clk); end
    check(n == 8, "R9 high phase kept whole", n, 8);
    measureHalf(1'b0, len);
    check(len == 4, "R9 new setting adopted", len, 4);

    // R8: enable gating and restart.
    phaseCheckOn = 1'b0;
    while (!cardClk) @(negedge clk);
    clkEn = 1'b0;
    @(negedge clk);
    check(cardClk == 1'b0, "R8 low after disable", int'(cardClk), 0);
    lowAll = 1'b1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (cardClk) lowAll = 1'b0;
    end
    check(lowAll, "R8 held low while disabled", int'(!lowAll), 0);
    clkEn = 1'b1;
    n = 0;
    while (!cardClk && n < 100) begin @(negedge clk); n++; end
    check(n >= 3 && n <= 5, "R8 restart low phase", n, 4);

    // R6: external clock follows one cycle later, divider selects ignored.
    srcSel = 1'b1;
    extClk = 1'b0;
    repeat (20) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      extClk = ((8'b10110010 >> i) & 8'd1) != 0;
      divA = i[0];
      divB = i[1];
      @(negedge clk);
      check(cardClk == extClk, "R6 card follows external", int'(cardClk), int'(extClk));
    end
    measureHalf(1'b1, len);
    check(len == 2, "R6 host is crystal", len, 2);

    // R7: low power from external mode stops the card clock.
    extClk = 1'b0;
    @(negedge clk);
    normalMode = 1'b0;
    extClk = 1'b1;
    repeat (3) @(negedge clk);
    lowAll = 1'b1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (cardClk) lowAll = 1'b0;
    end
    check(lowAll, "R7 card low in low power", int'(!lowAll), 0);

    finishRun();
  end

endmodule